// File: doc/BRIEF.md
# Watchdog Timer with Reset Generator

This block is a register-mapped watchdog. A 32-bit up-counter advances on each clock cycle where the `tick` input is high and counting is enabled. A single match register is compared against the counter. When a counted tick finds the counter equal to the match value, the block can do any of four things, each chosen by a control bit: raise an interrupt, drive a match output pin, stop and clear the counter, and request a reset. Reset requests come in two kinds. The first is a one-cycle internal system reset. The second is an active-low external reset pulse whose length is set in ticks. Software can also fire either reset at once, without waiting for a match.

Software uses a plain 32-bit bus: byte address, write enable, write data, and a combinational read-data path. Registers sit on word boundaries.

| Offset | Register |
|---|---|
| 0x00 | interrupt status |
| 0x04 | control |
| 0x08 | counter |
| 0x0C | match control |
| 0x10 | match value |
| 0x14 | match-output control |
| 0x18 | reset pulse length |
| 0x1C | reset cause |

The block has two reset inputs:
- `rst_n` is the ordinary system reset. It clears every register except one.
- `por_n` is the power-on reset. It alone clears the sticky flag that says a watchdog reset took place. The system asserts `rst_n` whenever `por_n` is asserted.

Top module: `wdt_resetgen`

## Requirements
- R1: After reset, every register reads 0, `irq` and `match_out` are 0, `sys_rst` is 0 and `ext_rst_n` is 1.
- R2: Control bit 0 enables counting. The counter (0x08) rises by one on each clock where `tick` is 1 and counting is enabled. It holds when `tick` is 0 or when bit 0 is clear.
- R3: Writing control with bit 1 set clears the counter on that write's clock edge. Bit 1 always reads back as 0.
- R4: With control bit 2 set and `dbg_halt` high, the counter is frozen. With bit 2 clear, `dbg_halt` has no effect. Control reads back bits 0 and 2.
- R5: A match occurs when a counted tick finds the counter equal to the match value (0x10). If match-control bit 0 is set, a match sets interrupt-status bit 0 and `irq`. Writing 1 to that bit clears it; writing 0 leaves it set.
- R6: With match-control bit 2 set, a match clears the counter and clears control bit 0. The counter then stays at 0 until control bit 0 is written to 1 again.
- R7: Match-output control (0x14) has bit 0, which is the `match_out` state and is writable, and field [5:4], the action taken on a match. The actions are: 0 none, 1 drive low, 2 drive high, 3 toggle.
- R8: A match with match-control bit 3 set, or a write of match control with bit 5 set, makes `sys_rst` high for exactly one cycle, starting at the same edge. Bits 5 and 6 are not stored and read as 0. Match control reads back bits 0, 2, 3 and 4.
- R9: A match with match-control bit 4 set, or a write of match control with bit 6 set, drives `ext_rst_n` low from that edge. It stays low for exactly pulse-length (0x18, 16 bits) plus 6 ticks.
- R10: Reset-cause bit 0 (0x1C) becomes 1 when the block issues either reset. It survives `rst_n`, is cleared only by `por_n`, and ignores writes.
- R11: Offsets above 0x1C read as 0. Writes to the counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, clears the reset-cause flag |
| tick | input | 1 | Counter tick enable, one clock wide per tick |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_addr | input | 6 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Match interrupt |
| match_out | output | 1 | Match output pin |
| sys_rst | output | 1 | Internal system reset pulse, active high |
| ext_rst_n | output | 1 | External reset pulse, active low |

## Verification
Read data is due in the same cycle as the address. A write takes effect at the next rising edge. The counter, `irq`, `match_out`, `sys_rst` and the start of the `ext_rst_n` pulse all change at the rising edge where the matching tick is sampled. The end of the `ext_rst_n` pulse comes at the edge of the last counted tick.

The bench drives every input just after a falling edge and samples just after the following falling edge. Tick counts are controlled exactly, one per cycle. As a result, each expected value is due at a known edge. `sys_rst` is checked to be high at the first sample after the triggering edge and low at the next. The external pulse is checked at one tick before its expected end and again at its end.

// File: rtl/wdt_resetgen.sv
module wdt_resetgen #(
  parameter int ADDR_W  = 6,
  parameter int CNT_W   = 32,
  parameter int PLEN_W  = 16,
  parameter int EXT_PAD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              tick,
  input  logic              dbg_halt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              match_out,
  output logic              sys_rst,
  output logic              ext_rst_n
);
  localparam int WI_W  = ADDR_W - 2;
  localparam int EXT_W = PLEN_W + 1;

  localparam logic [WI_W-1:0] W_INT  = WI_W'(0);
  localparam logic [WI_W-1:0] W_CTRL = WI_W'(1);
  localparam logic [WI_W-1:0] W_CNT  = WI_W'(2);
  localparam logic [WI_W-1:0] W_MCTL = WI_W'(3);
  localparam logic [WI_W-1:0] W_MVAL = WI_W'(4);
  localparam logic [WI_W-1:0] W_OUTC = WI_W'(5);
  localparam logic [WI_W-1:0] W_PLEN = WI_W'(6);
  localparam logic [WI_W-1:0] W_CAUS = WI_W'(7);

  logic [WI_W-1:0]   wsel;
  logic              cnt_en, dbg_frz, int_flag;
  logic              mc_ie, mc_stop, mc_irst, mc_erst;
  logic              out_q;
  logic [1:0]        out_act;
  logic [CNT_W-1:0]  cnt, match_val;
  logic [PLEN_W-1:0] plen;
  logic [EXT_W-1:0]  ext_left;
  logic              cause_q;
  logic              wr_int, wr_ctrl, wr_mctl, wr_mval, wr_outc, wr_plen;
  logic              run, hit, req_int, req_ext;
  logic              unused_bits;

  assign wsel    = bus_addr[ADDR_W-1:2];
  assign wr_int  = bus_we && (wsel == W_INT);
  assign wr_ctrl = bus_we && (wsel == W_CTRL);
  assign wr_mctl = bus_we && (wsel == W_MCTL);
  assign wr_mval = bus_we && (wsel == W_MVAL);
  assign wr_outc = bus_we && (wsel == W_OUTC);
  assign wr_plen = bus_we && (wsel == W_PLEN);

  assign run     = cnt_en && tick && !(dbg_frz && dbg_halt);
  assign hit     = run && (cnt == match_val);
  assign req_int = (hit && mc_irst) || (wr_mctl && bus_wdata[5]);
  assign req_ext = (hit && mc_erst) || (wr_mctl && bus_wdata[6]);

  assign irq       = int_flag;
  assign match_out = out_q;
  assign ext_rst_n = (ext_left == '0);
  assign unused_bits = ^{bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en  <= 1'b0;
      dbg_frz <= 1'b0;
      cnt     <= '0;
    end else begin
      if (wr_ctrl) begin
        cnt_en  <= bus_wdata[0];
        dbg_frz <= bus_wdata[2];
      end else if (hit && mc_stop) begin
        cnt_en  <= 1'b0;
      end
      if (wr_ctrl && bus_wdata[1])  cnt <= '0;
      else if (hit && mc_stop)      cnt <= '0;
      else if (run)                 cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_flag  <= 1'b0;
      mc_ie     <= 1'b0;
      mc_stop   <= 1'b0;
      mc_irst   <= 1'b0;
      mc_erst   <= 1'b0;
      match_val <= '0;
      plen      <= '0;
    end else begin
      int_flag <= (int_flag && !(wr_int && bus_wdata[0])) || (hit && mc_ie);
      if (wr_mctl) begin
        mc_ie   <= bus_wdata[0];
        mc_stop <= bus_wdata[2];
        mc_irst <= bus_wdata[3];
        mc_erst <= bus_wdata[4];
      end
      if (wr_mval) match_val <= bus_wdata[CNT_W-1:0];
      if (wr_plen) plen      <= bus_wdata[PLEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      out_act <= 2'd0;
    end else if (wr_outc) begin
      out_q   <= bus_wdata[0];
      out_act <= bus_wdata[5:4];
    end else if (hit) begin
      case (out_act)
        2'd1:    out_q <= 1'b0;
        2'd2:    out_q <= 1'b1;
        2'd3:    out_q <= !out_q;
        default: out_q <= out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst  <= 1'b0;
      ext_left <= '0;
    end else begin
      sys_rst <= req_int;
      if (req_ext)                         ext_left <= EXT_W'(plen) + EXT_W'(EXT_PAD);
      else if (tick && ext_left != '0)     ext_left <= ext_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  cause_q <= 1'b0;
    else if (req_int || req_ext) cause_q <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (wsel)
      W_INT:   bus_rdata[0] = int_flag;
      W_CTRL:  bus_rdata[2:0] = {dbg_frz, 1'b0, cnt_en};
      W_CNT:   bus_rdata[CNT_W-1:0] = cnt;
      W_MCTL:  bus_rdata[4:0] = {mc_erst, mc_irst, mc_stop, 1'b0, mc_ie};
      W_MVAL:  bus_rdata[CNT_W-1:0] = match_val;
      W_OUTC:  bus_rdata[5:0] = {out_act, 3'b000, out_q};
      W_PLEN:  bus_rdata[PLEN_W-1:0] = plen;
      W_CAUS:  bus_rdata[0] = cause_q;
      default: bus_rdata = '0;
    endcase
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R4
  dbg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_frz && dbg_halt && !wr_ctrl) |=> $stable(cnt));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && bus_wdata[0] && !hit) |=> !irq);

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mc_stop && !wr_ctrl) |=> (cnt == '0 && !cnt_en));

  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rst_n && !tick) |=> !ext_rst_n);

  // R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (sys_rst || !ext_rst_n) |-> cause_q);
endmodule

// File: tb/wdt_resetgen_bench.sv
module wdt_resetgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, tick = 1'b0, dbg_halt = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, match_out, sys_rst, ext_rst_n;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wdt_resetgen u_wdt_resetgen (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .dbg_halt(dbg_halt),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .match_out(match_out), .sys_rst(sys_rst), .ext_rst_n(ext_rst_n)
  );

  // {write, addr, data, expected read, requirement number}
  localparam int NV = 21;
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 6'h04, 32'h0000_0002, 32'h0, 4'd3},         // R3
    {1'b0, 6'h04, 32'h0, 32'h0000_0000, 4'd3},         // R3 bit 1 reads 0
    {1'b1, 6'h04, 32'h0000_0004, 32'h0, 4'd4},         // R4
    {1'b0, 6'h04, 32'h0, 32'h0000_0004, 4'd4},         // R4
    {1'b1, 6'h04, 32'h0000_0000, 32'h0, 4'd4},
    {1'b1, 6'h10, 32'h1234_5678, 32'h0, 4'd5},         // R5
    {1'b0, 6'h10, 32'h0, 32'h1234_5678, 4'd5},
    {1'b1, 6'h18, 32'hDEAD_1234, 32'h0, 4'd9},         // R9
    {1'b0, 6'h18, 32'h0, 32'h0000_1234, 4'd9},
    {1'b1, 6'h0C, 32'h0000_009F, 32'h0, 4'd8},         // R8
    {1'b0, 6'h0C, 32'h0, 32'h0000_001D, 4'd8},
    {1'b1, 6'h0C, 32'h0000_0000, 32'h0, 4'd8},
    {1'b1, 6'h14, 32'h0000_00F1, 32'h0, 4'd7},         // R7
    {1'b0, 6'h14, 32'h0, 32'h0000_0031, 4'd7},
    {1'b1, 6'h14, 32'h0000_0000, 32'h0, 4'd7},
    {1'b1, 6'h08, 32'h0000_0055, 32'h0, 4'd11},        // R11
    {1'b0, 6'h08, 32'h0, 32'h0000_0000, 4'd11},
    {1'b1, 6'h1C, 32'h0000_0001, 32'h0, 4'd10},        // R10
    {1'b0, 6'h1C, 32'h0, 32'h0000_0000, 4'd10},
    {1'b1, 6'h24, 32'h0000_FFFF, 32'h0, 4'd11},        // R11
    {1'b0, 6'h24, 32'h0, 32'h0000_0000, 4'd11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset(input bit with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
  endtask

  task automatic restart();
    wr(6'h04, 32'h2);
    wr(6'h04, 32'h1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(6'(a * 4), d);
      chk("R1", d, 32'h0, $sformatf("reg %0h after reset", a * 4));
    end
    chk("R1", {31'd0, irq}, 32'd0, "irq");
    chk("R1", {31'd0, match_out}, 32'd0, "match_out");
    chk("R1", {31'd0, sys_rst}, 32'd0, "sys_rst");
    chk("R1", {31'd0, ext_rst_n}, 32'd1, "ext_rst_n");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][74]) wr(VEC[i][73:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][73:68], d);
        chk($sformatf("R%0d", VEC[i][3:0]), d, VEC[i][35:4],
            $sformatf("vector %0d", i));
      end
    end

    // R2 counting
    wr(6'h04, 32'h1);
    ticks(5);
    rd(6'h08, d); chk("R2", d, 32'd5, "five ticks");
    repeat (3) @(negedge clk);
    rd(6'h08, d); chk("R2", d, 32'd5, "no tick hold");
    wr(6'h04, 32'h0);
    ticks(3);
    rd(6'h08, d); chk("R2", d, 32'd5, "disabled hold");

    // R3 counter clear
    wr(6'h04, 32'h2);
    rd(6'h08, d); chk("R3", d, 32'd0, "clear command");

    // R4 debug freeze
    wr(6'h04, 32'h5);
    dbg_halt = 1'b1;
    ticks(4);
    rd(6'h08, d); chk("R4", d, 32'd0, "frozen");
    dbg_halt = 1'b0;
    ticks(3);
    rd(6'h08, d); chk("R4", d, 32'd3, "unfrozen");
    wr(6'h04, 32'h1);
    dbg_halt = 1'b1;
    ticks(2);
    rd(6'h08, d); chk("R4", d, 32'd5, "halt ignored");
    dbg_halt = 1'b0;

    // R5 interrupt, R7 drive high
    wr(6'h10, 32'd4);
    wr(6'h0C, 32'h1);
    wr(6'h14, 32'h20);
    restart();
    ticks(4);
    chk("R5", {31'd0, irq}, 32'd0, "irq before match");
    ticks(1);
    chk("R5", {31'd0, irq}, 32'd1, "irq on match");
    chk("R7", {31'd0, match_out}, 32'd1, "drive high on match");
    wr(6'h00, 32'h0);
    rd(6'h00, d); chk("R5", d, 32'd1, "write 0 keeps");
    wr(6'h00, 32'h1);
    rd(6'h00, d); chk("R5", d, 32'd0, "write 1 clears");
    wr(6'h0C, 32'h0);

    // R7 toggle, drive low, none
    wr(6'h14, 32'h31);
    restart(); ticks(5);
    chk("R7", {31'd0, match_out}, 32'd0, "toggle");
    wr(6'h14, 32'h11);
    restart(); ticks(5);
    chk("R7", {31'd0, match_out}, 32'd0, "drive low");
    wr(6'h14, 32'h01);
    restart(); ticks(5);
    chk("R7", {31'd0, match_out}, 32'd1, "no action");
    chk("R5", {31'd0, irq}, 32'd0, "no irq when disabled");

    // R6 stop on match
    wr(6'h0C, 32'h4);
    restart(); ticks(5);
    rd(6'h08, d); chk("R6", d, 32'd0, "counter cleared");
    rd(6'h04, d); chk("R6", d, 32'd0, "enable dropped");
    ticks(3);
    rd(6'h08, d); chk("R6", d, 32'd0, "held at zero");
    wr(6'h04, 32'h1);
    ticks(2);
    rd(6'h08, d); chk("R6", d, 32'd2, "resumes");

    // R8 internal reset on match
    wr(6'h0C, 32'h8);
    restart(); ticks(4);
    chk("R8", {31'd0, sys_rst}, 32'd0, "before match");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R8", {31'd0, sys_rst}, 32'd1, "pulse high");
    @(negedge clk);
    chk("R8", {31'd0, sys_rst}, 32'd0, "pulse one cycle");
    rd(6'h1C, d); chk("R10", d, 32'd1, "cause set");

    // R10 survives system reset, cleared by power-on
    do_reset(1'b0);
    rd(6'h1C, d); chk("R10", d, 32'd1, "survives rst_n");
    rd(6'h04, d); chk("R1", d, 32'd0, "ctrl reset");
    do_reset(1'b1);
    rd(6'h1C, d); chk("R10", d, 32'd0, "cleared by por");

    // R8 forced internal reset
    wr(6'h0C, 32'h20);
    chk("R8", {31'd0, sys_rst}, 32'd1, "forced pulse");
    rd(6'h0C, d); chk("R8", d, 32'd0, "force not stored");
    @(negedge clk);
    chk("R8", {31'd0, sys_rst}, 32'd0, "forced one cycle");
    do_reset(1'b1);

    // R9 forced external pulse, length 3+6
    wr(6'h18, 32'd3);
    wr(6'h0C, 32'h40);
    chk("R9", {31'd0, ext_rst_n}, 32'd0, "forced low");
    ticks(8);
    chk("R9", {31'd0, ext_rst_n}, 32'd0, "low at 8 ticks");
    ticks(1);
    chk("R9", {31'd0, ext_rst_n}, 32'd1, "high at 9 ticks");
    rd(6'h1C, d); chk("R10", d, 32'd1, "cause from external");

    // R9 external pulse on match, length 0+6
    wr(6'h18, 32'd0);
    wr(6'h10, 32'd4);
    wr(6'h0C, 32'h10);
    restart(); ticks(4);
    chk("R9", {31'd0, ext_rst_n}, 32'd1, "before match");
    ticks(1);
    chk("R9", {31'd0, ext_rst_n}, 32'd0, "low on match");
    ticks(5);
    chk("R9", {31'd0, ext_rst_n}, 32'd0, "low at 5 ticks");
    ticks(1);
    chk("R9", {31'd0, ext_rst_n}, 32'd1, "high at 6 ticks");

    done = 1'b1;
    summary();
  end
endmodule